// File: doc/BRIEF.md
# Latched BCD Seven-Segment Decoder

This block turns a four-bit binary-coded decimal digit into the seven active-high drive lines of a common-cathode display. A clocked holding register sits in front of the decoder. While the hold control is low, the register takes a new digit on every clock. While the hold control is high, the register keeps its digit and the display stays frozen.

Two active-low overrides act on the outputs only. The test input lights every segment. The blanking input darkens every segment. The test input wins over blanking. Neither override changes what the holding register stores, so releasing an override shows the held digit again.

The outputs are combinational in the stored digit and the two overrides. An override therefore appears in the same cycle it is asserted. A new digit appears one clock after it is loaded.

Top module: `seg7_latch_decoder`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears the stored digit to 0, so with both overrides inactive the segments read 7'h3F after reset.
- R2: With hold low, each rising clock edge loads digit_in into the stored digit, and seg shows its pattern directly after that edge.
- R3: With hold high at a rising edge, the stored digit is kept, and seg does not change however digit_in moves.
- R4: With test_n and blank_n high, digits 0 to 9 give seg (bit 0 = a, bit 1 = b, ... bit 6 = g) = 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F in hex.
- R5: With test_n and blank_n high, stored codes 10 to 15 give seg = 7'h00.
- R6: test_n low drives seg to 7'h7F in the same cycle, whatever every other input is.
- R7: test_n high with blank_n low drives seg to 7'h00 in the same cycle.
- R8: test_n and blank_n have no effect on loading or holding, so once both return high seg shows the digit that storage alone would hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| digit_in | input | 4 | BCD digit to store |
| hold | input | 1 | High keeps the stored digit, low loads on each clock |
| blank_n | input | 1 | Active-low blanking: all segments off |
| test_n | input | 1 | Active-low lamp test: all segments on, highest priority |
| seg | output | 7 | Segment drives, bit 0 = a through bit 6 = g |

## Verification
The assertions assume that every input is driven to a known 0 or 1 from the first clock edge and that reset is held for at least one edge before any check counts. They also assume that inputs only change between clock edges, so each sampled value is a settled level. The bench drives every input on the falling edge, starts with reset high, and draws the random values of digit_in, hold, blank_n and test_n from a seeded $urandom stream. None of these values can be unknown.

// File: rtl/seg7_latch_decoder.sv
module seg7_latch_decoder #(
  parameter int DIGIT_W = 4,
  parameter int SEG_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] digit_in,
  input  logic               hold,
  input  logic               blank_n,
  input  logic               test_n,
  output logic [SEG_W-1:0]   seg
);

  localparam logic [SEG_W-1:0] ALL_ON  = {SEG_W{1'b1}};
  localparam logic [SEG_W-1:0] ALL_OFF = {SEG_W{1'b0}};

  logic [DIGIT_W-1:0] stored;
  logic [SEG_W-1:0]   pattern;

  always_ff @(posedge clk) begin
    if (rst)        stored <= '0;
    else if (!hold) stored <= digit_in;
  end

  always_comb begin
    case (stored)
      4'd0:    pattern = 7'h3F;
      4'd1:    pattern = 7'h06;
      4'd2:    pattern = 7'h5B;
      4'd3:    pattern = 7'h4F;
      4'd4:    pattern = 7'h66;
      4'd5:    pattern = 7'h6D;
      4'd6:    pattern = 7'h7D;
      4'd7:    pattern = 7'h07;
      4'd8:    pattern = 7'h7F;
      4'd9:    pattern = 7'h6F;
      default: pattern = ALL_OFF;
    endcase
  end

  assign seg = !test_n  ? ALL_ON  :
               !blank_n ? ALL_OFF : pattern;

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (!test_n || !blank_n || seg == 7'h3F)); // R1
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (hold && test_n && blank_n) ##1 (test_n && blank_n) |-> $stable(seg)); // R3
  AST_LIT_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (test_n && blank_n && seg != ALL_OFF) |-> $countones(seg) >= 2); // R4
  AST_BAD_CODE_DARK: assert property (@(posedge clk) disable iff (rst)
    (!hold && digit_in > 4'd9) |=> (!test_n || !blank_n || seg == ALL_OFF)); // R5
  AST_TEST_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    !test_n |-> seg == ALL_ON); // R6
  AST_BLANK_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (test_n && !blank_n) |-> seg == ALL_OFF); // R7
  AST_OVERRIDE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (hold && (!test_n || !blank_n)) ##1 (test_n && blank_n && $past(hold, 2) && $past(test_n, 2) && $past(blank_n, 2))
      |-> seg == $past(seg, 2)); // R8

endmodule

// File: tb/test_seg7_latch_decoder.sv
module test_seg7_latch_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] digit_in = '0;
  logic       hold = 1'b0;
  logic       blank_n = 1'b1;
  logic       test_n = 1'b1;
  logic [6:0] seg;

  int vectors = 0;
  int fails = 0;
  logic [3:0] model = '0;
  logic       prev_hold = 1'b0;

  seg7_latch_decoder i_seg7_latch_decoder (
    .clk(clk), .rst(rst), .digit_in(digit_in), .hold(hold),
    .blank_n(blank_n), .test_n(test_n), .seg(seg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] ref_pattern(input logic [3:0] d);
    case (d)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] ref_seg(input logic [3:0] d, input logic b, input logic t);
    if (!t) return 7'h7F;
    if (!b) return 7'h00;
    return ref_pattern(d);
  endfunction

  task automatic check(input string tag, input logic [6:0] exp);
    vectors++;
    if (seg !== exp) begin
      fails++;
      $display("FAIL %s: seg=%h expected=%h", tag, seg, exp);
    end
  endtask

  task automatic auto_check();
    string tag;
    if (!test_n)          tag = "R6";
    else if (!blank_n)    tag = "R7";
    else if (prev_hold)   tag = "R3";
    else if (model > 4'd9) tag = "R5";
    else                  tag = "R4";
    check(tag, ref_seg(model, blank_n, test_n));
  endtask

  task automatic step(input logic [3:0] d, input logic h, input logic b, input logic t);
    @(negedge clk);
    digit_in = d; hold = h; blank_n = b; test_n = t;
    #1;
    auto_check();
    @(posedge clk);
    if (rst) model = '0;
    else if (!h) model = d;
    prev_hold = h;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: seg=%h expected=finish", seg);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4511));
    step(4'd5, 1'b0, 1'b1, 1'b1);
    step(4'd5, 1'b0, 1'b1, 1'b1);
    @(negedge clk); rst = 1'b0; digit_in = 4'd8; hold = 1'b1; #1;
    check("R1", 7'h3F);
    @(posedge clk); model = '0; prev_hold = 1'b1;

    step(4'd2, 1'b0, 1'b1, 1'b1);
    @(negedge clk); hold = 1'b1; digit_in = 4'd9; #1;
    check("R2", 7'h5B);
    @(posedge clk); prev_hold = 1'b1;
    step(4'd7, 1'b1, 1'b1, 1'b1);
    step(4'd0, 1'b1, 1'b1, 1'b1);
    @(negedge clk); #1; check("R3", 7'h5B); @(posedge clk);

    step(4'd3, 1'b0, 1'b0, 1'b1);
    @(negedge clk); hold = 1'b1; blank_n = 1'b1; digit_in = 4'd1; #1;
    check("R8", 7'h4F);
    @(posedge clk); prev_hold = 1'b1;
    step(4'd6, 1'b1, 1'b1, 1'b0);
    step(4'd6, 1'b1, 1'b0, 1'b0);
    @(negedge clk); blank_n = 1'b1; test_n = 1'b1; #1;
    check("R8", 7'h4F);
    @(posedge clk);

    for (int code = 0; code < 16; code++) begin
      for (int combo = 0; combo < 8; combo++) begin
        step(4'(code), combo[0], combo[1], combo[2]);
        step(4'(15 - code), 1'b1, 1'b1, 1'b1);
        step(4'(code), 1'b0, 1'b1, 1'b1);
        step(4'(code), 1'b1, 1'b1, 1'b1);
      end
    end

    for (int n = 0; n < 2000; n++) begin
      logic [3:0] d = 4'($urandom_range(15));
      logic h = ($urandom_range(3) == 0);
      logic b = ($urandom_range(4) != 0);
      logic t = ($urandom_range(5) != 0);
      step(d, h, b, t);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule